// File: doc/BRIEF.md
# Fractional-Ratio Serial Clock Prescaler

This block produces the internal timing strobe that paces a two-wire serial bus controller. It counts clock-enable strobes from one of two candidate sources, both sampled in a single master clock domain. It emits a one-cycle strobe each time the selected divide ratio is reached. The ratios are 2, 2.5, 3, 4, 5, 6 and 8. A 3-bit extended field takes priority over a 2-bit base field when it picks the ratio. The 2.5 ratio is produced by a phase bit that makes successive periods alternate between 2 and 3 source enables.

Configuration is sampled into an active register at three points: right after reset, right after a gating interval, and at every output strobe. A setting written in mid-period therefore never shortens or stretches the period in progress. A stop/low-power gate input holds the prescaler in a cleared state, and no strobe is produced while it is high. An illegal ratio code raises a flag and silences the strobe; the block does not fall back to some other ratio. It has no streaming data path, so every pin is a plain control or status signal with no back-pressure.

Top module: `frac_clk_prescaler`

## Requirements
- R1: A synchronous active-high reset clears the output strobe and the illegal flag, and makes divide-by-2 from source A the active setting.
- R2: With the extended field at 000, the base field selects the ratio: 00 gives one strobe per 2 source enables, 01 one per 4, and 10 one per 8.
- R3: With a nonzero extended field the base field is ignored: 010 gives one strobe per 3 enables, 011 one per 5, and 100 one per 6.
- R4: Extended code 001 selects ratio 2.5. The first period after a load lasts 2 enables, the next lasts 3, and they keep alternating, so there are exactly 2 strobes per 5 enables.
- R5: Extended codes 101, 110 and 111, and extended 000 with base 11, are illegal. When such a setting becomes active, the illegal flag goes high and no strobe is produced. A legal setting is picked up in the cycle after it is applied.
- R6: Source select 0 counts enables from source A and 1 counts enables from source B. Enables on the unselected source have no effect.
- R7: A change to the ratio fields or the source select becomes active only at the next output strobe. Counting of the next period then starts from zero.
- R8: While the gate input is high, no strobe is produced and the count and phase are cleared. After release there is one load cycle, then the first strobe follows a full period of the new setting, starting from phase 0.
- R9: The strobe is registered. It is high for exactly one cycle, in the cycle after the enable that completes a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| src_a_en | input | 1 | Enable strobe of source clock A |
| src_b_en | input | 1 | Enable strobe of source clock B |
| src_sel | input | 1 | Source select: 0 = A, 1 = B |
| ext_ratio | input | 3 | Extended ratio code, takes priority when nonzero |
| base_ratio | input | 2 | Base ratio code, used when the extended code is 000 |
| gate_off | input | 1 | Stop/low-power gate, high holds the prescaler idle |
| tick_o | output | 1 | One-cycle output strobe at the divided rate |
| bad_cfg_o | output | 1 | High while the active setting is illegal |

## Verification
The bench targets the alternation of the 2.5 ratio. A design without the phase bit gives 1 or 3 strobes in a five-enable window instead of 2, and one that starts in the wrong phase shifts the first strobe after a load by one enable. Ratio and source changes are made in mid-period. A design that applied them at once would fire early or late compared with the cycle-exact model. Gating is applied in mid-count and an unselected source is toggled. A design that kept a partial count through the gate, or that counted the wrong source, fires a strobe the model does not expect. All illegal codes are exercised; a design that fell back to a default ratio would strobe while the flag is high.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  // Decoded ratio: terminal count of the short period, plus a flag for the
  // alternating half-step mode (the long period ends one count later).
  typedef struct packed {
    logic       legal;
    logic       frac;
    logic [3:0] term;
  } ratio_t;

  typedef struct packed {
    logic       src;
    logic [2:0] ext;
    logic [1:0] base;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{src: 1'b0, ext: 3'd0, base: 2'd0};

endpackage

// File: rtl/fdiv_ratio_decode.sv
module fdiv_ratio_decode
  import fdiv_pkg::*;
(
  input  logic [2:0] ext,
  input  logic [1:0] base,
  output ratio_t     ratio
);

  always_comb begin
    ratio = '{legal: 1'b1, frac: 1'b0, term: 4'd1};
    case (ext)
      3'd0: begin
        case (base)
          2'd0:    ratio.term = 4'd1;
          2'd1:    ratio.term = 4'd3;
          2'd2:    ratio.term = 4'd7;
          default: ratio.legal = 1'b0;
        endcase
      end
      3'd1: begin
        ratio.term = 4'd1;
        ratio.frac = 1'b1;
      end
      3'd2:    ratio.term = 4'd2;
      3'd3:    ratio.term = 4'd4;
      3'd4:    ratio.term = 4'd5;
      default: ratio.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/fdiv_src_mux.sv
module fdiv_src_mux #(
  parameter int N_SRC = 2,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] en_vec,
  input  logic [SEL_W-1:0] sel,
  output logic             en
);

  always_comb begin
    en = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel == SEL_W'(i)) en = en_vec[i];
    end
  end

endmodule

// File: rtl/fdiv_pacer.sv
module fdiv_pacer
  import fdiv_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   gate,
  input  logic   en,
  input  cfg_t   cfg_live,
  input  ratio_t ratio_act,
  output cfg_t   cfg_act,
  output logic   tick
);

  logic             armed_q;
  logic             phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term_now;
  logic             reload;

  assign term_now = CNT_W'(ratio_act.term) + CNT_W'(ratio_act.frac & phase_q);
  assign reload   = armed_q | ~ratio_act.legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b1;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      tick    <= 1'b0;
      cfg_act <= CFG_RESET;
    end else if (gate) begin
      armed_q <= 1'b1;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      tick    <= 1'b0;
    end else if (reload) begin
      armed_q <= 1'b0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      tick    <= 1'b0;
      cfg_act <= cfg_live;
    end else if (en) begin
      if (cnt_q == term_now) begin
        tick    <= 1'b1;
        cnt_q   <= '0;
        phase_q <= ratio_act.frac ? ~phase_q : 1'b0;
        cfg_act <= cfg_live;
      end else begin
        tick  <= 1'b0;
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/frac_clk_prescaler.sv
module frac_clk_prescaler
  import fdiv_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       src_a_en,
  input  logic       src_b_en,
  input  logic       src_sel,
  input  logic [2:0] ext_ratio,
  input  logic [1:0] base_ratio,
  input  logic       gate_off,
  output logic       tick_o,
  output logic       bad_cfg_o
);

  cfg_t   cfg_live;
  cfg_t   cfg_act;
  ratio_t ratio_act;
  logic   sel_en;

  assign cfg_live = '{src: src_sel, ext: ext_ratio, base: base_ratio};

  fdiv_ratio_decode u_dec (
    .ext   (cfg_act.ext),
    .base  (cfg_act.base),
    .ratio (ratio_act)
  );

  fdiv_src_mux #(.N_SRC(2)) u_mux (
    .en_vec ({src_b_en, src_a_en}),
    .sel    (cfg_act.src),
    .en     (sel_en)
  );

  fdiv_pacer #(.CNT_W(CNT_W)) u_pace (
    .clk       (clk),
    .rst       (rst),
    .gate      (gate_off),
    .en        (sel_en),
    .cfg_live  (cfg_live),
    .ratio_act (ratio_act),
    .cfg_act   (cfg_act),
    .tick      (tick_o)
  );

  assign bad_cfg_o = ~ratio_act.legal;

endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker (
  input logic clk,
  input logic rst,
  input logic gate_off,
  input logic tick_o,
  input logic bad_cfg_o
);

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!tick_o && !bad_cfg_o));

  // R9
  a_r9_single_cycle: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

  // R8
  a_r8_gate_quiet: assert property (@(posedge clk) disable iff (rst)
    gate_off |=> !tick_o);

  // R5
  a_r5_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    (bad_cfg_o && $past(bad_cfg_o)) |-> !tick_o);

endmodule

bind frac_clk_prescaler fdiv_checker chk_i (
  .clk       (clk),
  .rst       (rst),
  .gate_off  (gate_off),
  .tick_o    (tick_o),
  .bad_cfg_o (bad_cfg_o)
);

// File: tb/frac_clk_prescaler_tb_top.sv
`timescale 1ns/1ps
module frac_clk_prescaler_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       src_a_en = 1'b0;
  logic       src_b_en = 1'b0;
  logic       src_sel = 1'b0;
  logic [2:0] ext_ratio = 3'd0;
  logic [1:0] base_ratio = 2'd0;
  logic       gate_off = 1'b0;
  logic       tick_o;
  logic       bad_cfg_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  frac_clk_prescaler dut_i (
    .clk(clk), .rst(rst), .src_a_en(src_a_en), .src_b_en(src_b_en),
    .src_sel(src_sel), .ext_ratio(ext_ratio), .base_ratio(base_ratio),
    .gate_off(gate_off), .tick_o(tick_o), .bad_cfg_o(bad_cfg_o)
  );

  // Terminal count (enables per period minus one); -1 marks an illegal code.
  function automatic int m_term(logic [2:0] e, logic [1:0] b, logic ph);
    case (e)
      3'd0: return (b == 2'd0) ? 1 : (b == 2'd1) ? 3 : (b == 2'd2) ? 7 : -1;
      3'd1: return ph ? 2 : 1;
      3'd2: return 2;
      3'd3: return 4;
      3'd4: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic string m_tag(logic g, logic [2:0] e, logic [1:0] b);
    if (g) return "R8";
    if (m_term(e, b, 1'b0) < 0) return "R5";
    if (e == 3'd1) return "R4";
    if (e != 3'd0) return "R3";
    return "R2";
  endfunction

  // Cycle-level reference model built from the requirements
  bit         m_armed, m_ph, m_tick, m_src;
  int         m_cnt;
  logic [2:0] m_ext;
  logic [1:0] m_base;

  always @(posedge clk) begin
    if (rst) begin
      m_armed = 1; m_ph = 0; m_cnt = 0; m_tick = 0;
      m_src = 0; m_ext = 0; m_base = 0;
    end else if (gate_off) begin
      m_armed = 1; m_ph = 0; m_cnt = 0; m_tick = 0;
    end else if (m_armed || m_term(m_ext, m_base, 1'b0) < 0) begin
      m_armed = 0; m_ph = 0; m_cnt = 0; m_tick = 0;
      m_src = src_sel; m_ext = ext_ratio; m_base = base_ratio;
    end else if (m_src ? src_b_en : src_a_en) begin
      if (m_cnt == m_term(m_ext, m_base, m_ph)) begin
        m_tick = 1; m_cnt = 0;
        m_ph = (m_ext == 3'd1) ? ~m_ph : 1'b0;
        m_src = src_sel; m_ext = ext_ratio; m_base = base_ratio;
      end else begin
        m_tick = 0; m_cnt++;
      end
    end else begin
      m_tick = 0;
    end
  end

  task automatic check(string tag, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    check(m_tag(gate_off, m_ext, m_base), tick_o, m_tick, "tick_o");
    check((m_term(m_ext, m_base, 1'b0) < 0) ? "R5" : "R7", bad_cfg_o,
          (m_term(m_ext, m_base, 1'b0) < 0), "bad_cfg_o");
  endtask

  task automatic step();
    @(negedge clk);
    cmp_model();
  endtask

  task automatic set_cfg(logic s, logic [2:0] e, logic [1:0] b);
    src_sel = s; ext_ratio = e; base_ratio = b;
  endtask

  // Count strobes over n cycles with continuous enables on both sources
  task automatic count_ticks(int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (tick_o) cnt++;
    end
  endtask

  task automatic count_check(string tag, logic s, logic [2:0] e, logic [1:0] b,
                             int n, int exp);
    int c;
    set_cfg(s, e, b);
    gate_off = 1; step(); gate_off = 0;
    step();                     // load cycle
    count_ticks(n, c);
    n_chk++;
    if (c != exp) begin
      n_fail++;
      $display("FAIL %s strobe count: actual %0d expected %0d", tag, c, exp);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int dummy;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1", tick_o, 1'b0, "tick_o after reset");
    check("R1", bad_cfg_o, 1'b0, "bad_cfg_o after reset");

    // Directed counts, all enables high
    src_a_en = 1; src_b_en = 1;
    count_check("R2", 0, 3'd0, 2'd0, 40, 20);
    count_check("R2", 0, 3'd0, 2'd1, 40, 10);
    count_check("R2", 0, 3'd0, 2'd2, 40, 5);
    count_check("R3", 0, 3'd2, 2'd3, 39, 13);
    count_check("R3", 1, 3'd3, 2'd1, 40, 8);
    count_check("R3", 0, 3'd4, 2'd2, 42, 7);
    count_check("R4", 0, 3'd1, 2'd0, 50, 20);
    count_check("R4", 1, 3'd1, 2'd3, 2, 1);     // first period is the short one
    count_check("R5", 0, 3'd0, 2'd3, 40, 0);
    count_check("R5", 0, 3'd5, 2'd0, 20, 0);
    count_check("R5", 0, 3'd7, 2'd2, 20, 0);
    // R6: selected source B idle, A toggling -> nothing
    src_b_en = 0;
    count_check("R6", 1, 3'd0, 2'd0, 40, 0);
    count_check("R6", 0, 3'd0, 2'd0, 40, 20);
    src_b_en = 1;

    // R7: mid-period change from /8 to /2 waits for the /8 boundary
    set_cfg(0, 3'd0, 2'd2);
    gate_off = 1; step(); gate_off = 0; step();
    repeat (3) step();
    set_cfg(0, 3'd0, 2'd0);
    count_ticks(5, dummy);
    n_chk++;
    if (dummy != 1) begin
      n_fail++;
      $display("FAIL R7 strobes in rest of /8 period: actual %0d expected 1", dummy);
    end
    count_ticks(10, dummy);
    n_chk++;
    if (dummy != 5) begin
      n_fail++;
      $display("FAIL R7 strobes after switch to /2: actual %0d expected 5", dummy);
    end

    // Constrained random segments checked cycle by cycle against the model
    for (int seg = 0; seg < 80; seg++) begin
      int pa = $urandom_range(20, 100);
      int pb = $urandom_range(20, 100);
      set_cfg($urandom_range(0, 1), 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)));
      if ($urandom_range(0, 3) != 0 && ext_ratio > 3'd4) ext_ratio = 3'($urandom_range(0, 4));
      for (int c = 0; c < 150; c++) begin
        step();
        src_a_en = ($urandom_range(1, 100) <= pa);
        src_b_en = ($urandom_range(1, 100) <= pb);
        gate_off = ($urandom_range(0, 99) < 3);
        if ($urandom_range(0, 59) == 0)
          set_cfg($urandom_range(0, 1), 3'($urandom_range(0, 4)), 2'($urandom_range(0, 2)));
      end
    end

    // R1 again: reset in mid-run
    rst = 1; step(); step(); rst = 0;
    check("R1", tick_o, 1'b0, "tick_o after mid-run reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule